// File: doc/BRIEF.md
# HDR-DDR Word Framer with CRC5

This block turns 16-bit payloads into the 20-bit words that a double-data-rate high-speed transfer on an I3C bus carries. Each incoming payload comes with a kind code: a command, the first data word of a transfer, a following data word, or a request for the closing CRC word. The output word has a two-bit preamble at the top that depends on the kind, the payload in the middle, and two interleaved parity bits at the bottom.

A five-bit CRC absorbs every data payload of a transfer, sixteen bits per clock, and is placed in the terminator word. A single-cycle start-of-transfer pulse presets the CRC to all ones. If a CRC word is requested before any data word has been absorbed, the block still emits the preset value and sets a sticky error flag.

Both sides use valid/ready handshakes. The output side has one register stage. A new word is taken whenever that stage is empty or is being drained in the same cycle.

Top module: `ddr_word_framer`

## Requirements
- R1: The output word is laid out as preamble in bits [19:18], payload in [17:2] and parity in [1:0]. The preamble is 2'b01 for kind 0 (command), 2'b10 for kind 1 (first data) and 2'b11 for kind 2 (following data).
- R2: For command and data words, output bit 1 is the XOR of payload bits 15, 13, 11, 9, 7, 5, 3 and 1.
- R3: For command and data words, output bit 0 is the inverse of the XOR of payload bits 14, 12, 10, 8, 6, 4, 2 and 0.
- R4: A command payload passes through unchanged, so a read command with payload bit 15 set appears with bit 17 of the word set.
- R5: Kind 3 (CRC) produces preamble 2'b01, the value 4'hC in bits [17:14], the CRC in bits [13:9], and zeros in bits [8:0]. The payload input is ignored for this kind.
- R6: The CRC starts at 5'h1F. It absorbs only data payloads, MSB first, one bit at a time: with fb = bit ^ crc[4], the next value is {crc[3], crc[2], crc[1]^fb, crc[0], fb}. A whole payload is absorbed in the cycle its word is accepted.
- R7: A start-of-transfer pulse presets the CRC to 5'h1F. When the pulse coincides with an accepted word, that word is framed after the preset.
- R8: A CRC word accepted with no data word absorbed since the last start-of-transfer (or since reset) carries 5'h1F and sets proto_err. proto_err stays set until reset.
- R9: in_ready equals !out_valid || out_ready. An accepted word appears on out_word with out_valid high in the next cycle. The word is held unchanged while out_ready is low.
- R10: After reset out_valid is 0, proto_err is 0 and in_ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sot | input | 1 | Start-of-transfer pulse, presets the CRC |
| in_valid | input | 1 | Payload and kind are valid |
| in_ready | output | 1 | Framer can accept a word this cycle |
| in_kind | input | 2 | 0 command, 1 first data, 2 following data, 3 CRC |
| in_payload | input | 16 | Command or data payload |
| out_valid | output | 1 | out_word holds a framed word |
| out_ready | input | 1 | Downstream takes the word |
| out_word | output | 20 | Framed 20-bit word |
| proto_err | output | 1 | Sticky: CRC word requested before any data |

## Verification
The assertions assume that sot and the handshake inputs are never unknown after reset, and that downstream honours the hold rule. Under that rule, a word still on out_word while out_ready is low is the same word in the next cycle. The parity property looks only at data words, because a CRC word and a command share a preamble. The bench drives inputs only on the falling edge. It presents each item until it is accepted, and it applies sot together with the first item of a transfer. Downstream stalls come from a bench LFSR and from forced stall windows, so every input combination the properties rely on occurs.

// File: rtl/ddr_frame_pkg.sv
package ddr_frame_pkg;
    localparam int PAY_W  = 16;
    localparam int CRC_W  = 5;
    localparam int PRE_W  = 2;
    localparam int PAR_W  = 2;
    localparam int WORD_W = PRE_W + PAY_W + PAR_W;
    localparam int TAG_W  = 4;
    localparam int PAD_W  = PAY_W - TAG_W - CRC_W;

    typedef enum logic [1:0] {
        K_CMD    = 2'd0,
        K_DFIRST = 2'd1,
        K_DNEXT  = 2'd2,
        K_CRC    = 2'd3
    } word_kind_e;

    localparam logic [PRE_W-1:0] PRE_CMD    = 2'b01;
    localparam logic [PRE_W-1:0] PRE_DFIRST = 2'b10;
    localparam logic [PRE_W-1:0] PRE_DNEXT  = 2'b11;
    localparam logic [TAG_W-1:0] CRC_TAG    = 4'hC;
    localparam logic [CRC_W-1:0] CRC_SEED   = '1;

    typedef struct packed {
        logic [PRE_W-1:0] pre;
        logic [PAY_W-1:0] pay;
        logic [PAR_W-1:0] par;
    } ddr_word_t;

    function automatic logic [PAR_W-1:0] pair_parity(input logic [PAY_W-1:0] p);
        logic odd_x;
        logic even_x;
        odd_x  = 1'b0;
        even_x = 1'b1;
        for (int i = 0; i < PAY_W; i += 2) begin
            even_x ^= p[i];
            odd_x  ^= p[i+1];
        end
        return {odd_x, even_x};
    endfunction

    function automatic logic [CRC_W-1:0] crc5_absorb(input logic [CRC_W-1:0] c_in,
                                                      input logic [PAY_W-1:0] p);
        logic [CRC_W-1:0] c;
        logic fb;
        c = c_in;
        for (int i = PAY_W - 1; i >= 0; i--) begin
            fb = p[i] ^ c[4];
            c  = {c[3], c[2], c[1] ^ fb, c[0], fb};
        end
        return c;
    endfunction

    function automatic logic kind_is_data(input word_kind_e k);
        return (k == K_DFIRST) || (k == K_DNEXT);
    endfunction
endpackage

// File: rtl/ddr_crc5_accum.sv
module ddr_crc5_accum
    import ddr_frame_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             sot,
    input  logic             absorb,
    input  logic [PAY_W-1:0] payload,
    output logic [CRC_W-1:0] crc_now,
    output logic             seen_now
);
    logic [CRC_W-1:0] crc_q;
    logic             seen_q;

    assign crc_now  = sot ? CRC_SEED : crc_q;
    assign seen_now = sot ? 1'b0 : seen_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            crc_q  <= CRC_SEED;
            seen_q <= 1'b0;
        end else if (absorb) begin
            crc_q  <= crc5_absorb(crc_now, payload);
            seen_q <= 1'b1;
        end else begin
            crc_q  <= crc_now;
            seen_q <= seen_now;
        end
    end

    // R7: a start pulse without a data word leaves the preset state behind
    p_seed_after_sot_r7: assert property (@(posedge clk) disable iff (rst)
        (sot && !absorb) |=> (crc_q == CRC_SEED) && !seen_q);
endmodule

// File: rtl/ddr_word_build.sv
module ddr_word_build
    import ddr_frame_pkg::*;
(
    input  word_kind_e       kind,
    input  logic [PAY_W-1:0] payload,
    input  logic [CRC_W-1:0] crc,
    output ddr_word_t        word
);
    always_comb begin
        word.pay = payload;
        word.par = pair_parity(payload);
        unique case (kind)
            K_CMD:    word.pre = PRE_CMD;
            K_DFIRST: word.pre = PRE_DFIRST;
            K_DNEXT:  word.pre = PRE_DNEXT;
            default: begin
                word.pre = PRE_CMD;
                word.pay = {CRC_TAG, crc, {PAD_W{1'b0}}};
                word.par = '0;
            end
        endcase
    end
endmodule

// File: rtl/ddr_out_stage.sv
module ddr_out_stage
    import ddr_frame_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      load,
    input  ddr_word_t word_in,
    input  logic      out_ready,
    output logic      out_valid,
    output ddr_word_t word_q,
    output logic      room
);
    assign room = !out_valid || out_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            word_q    <= '0;
        end else if (load) begin
            out_valid <= 1'b1;
            word_q    <= word_in;
        end else if (out_ready) begin
            out_valid <= 1'b0;
        end
    end

    // R9: a stalled word is held unchanged
    p_hold_stable_r9: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> out_valid && $stable(word_q));
endmodule

// File: rtl/ddr_word_framer.sv
module ddr_word_framer
    import ddr_frame_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sot,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [1:0]        in_kind,
    input  logic [PAY_W-1:0]  in_payload,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [WORD_W-1:0] out_word,
    output logic              proto_err
);
    word_kind_e       kind;
    logic             take;
    logic [CRC_W-1:0] crc_now;
    logic             seen_now;
    ddr_word_t        built;
    ddr_word_t        held;

    assign kind = word_kind_e'(in_kind);
    assign take = in_valid && in_ready;

    ddr_crc5_accum u_crc (
        .clk      (clk),
        .rst      (rst),
        .sot      (sot),
        .absorb   (take && kind_is_data(kind)),
        .payload  (in_payload),
        .crc_now  (crc_now),
        .seen_now (seen_now)
    );

    ddr_word_build u_build (
        .kind    (kind),
        .payload (in_payload),
        .crc     (crc_now),
        .word    (built)
    );

    ddr_out_stage u_out (
        .clk       (clk),
        .rst       (rst),
        .load      (take),
        .word_in   (built),
        .out_ready (out_ready),
        .out_valid (out_valid),
        .word_q    (held),
        .room      (in_ready)
    );

    assign out_word = held;

    always_ff @(posedge clk) begin
        if (rst)
            proto_err <= 1'b0;
        else if (take && kind == K_CRC && !seen_now)
            proto_err <= 1'b1;
    end

    // R8: the error flag never clears without reset
    p_err_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        proto_err |=> proto_err);

    // R1: a valid word never carries the unused preamble 2'b00
    p_preamble_legal_r1: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_word[19:18] != 2'b00));

    // R2: odd-position parity on data words
    p_parity_odd_r2: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_word[19]) |->
        (out_word[1] == ^{out_word[17], out_word[15], out_word[13], out_word[11],
                          out_word[9], out_word[7], out_word[5], out_word[3]}));
endmodule

// File: tb/sim_ddr_word_framer.sv
module sim_ddr_word_framer;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sot = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [1:0]  in_kind = 2'd0;
    logic [15:0] in_payload = 16'h0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [19:0] out_word;
    logic        proto_err;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    ddr_word_framer u0 (
        .clk(clk), .rst(rst), .sot(sot), .in_valid(in_valid), .in_ready(in_ready),
        .in_kind(in_kind), .in_payload(in_payload), .out_valid(out_valid),
        .out_ready(out_ready), .out_word(out_word), .proto_err(proto_err)
    );

    int          q_kind[$];
    logic [15:0] q_pay[$];
    bit          q_sot[$];
    int          q_stall[$];

    task automatic push(input int k, input logic [15:0] p, input bit s, input int stall);
        q_kind.push_back(k);
        q_pay.push_back(p);
        q_sot.push_back(s);
        q_stall.push_back(stall);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [4:0] ref_crc(input logic [4:0] c0, input logic [15:0] p);
        int c;
        int fb;
        c = c0;
        for (int i = 15; i >= 0; i--) begin
            fb = ((p >> i) & 1) ^ ((c >> 4) & 1);
            c  = ((c << 1) & 5'b11010) | ((((c >> 1) & 1) ^ fb) << 2) | fb;
        end
        return c[4:0];
    endfunction

    function automatic logic [19:0] ref_word(input int k, input logic [15:0] p, input logic [4:0] c);
        int o;
        int e;
        o = 0;
        e = 0;
        for (int i = 0; i < 16; i++) begin
            if (i % 2 == 1) o = o ^ p[i];
            else            e = e ^ p[i];
        end
        case (k)
            0: return {2'b01, p, o[0], ~e[0]};
            1: return {2'b10, p, o[0], ~e[0]};
            2: return {2'b11, p, o[0], ~e[0]};
            default: return {2'b01, 4'hC, c, 9'b0};
        endcase
    endfunction

    bit          mv = 1'b0;
    bit          merr = 1'b0;
    logic [19:0] mword = '0;
    int          mkind = 0;
    logic [4:0]  mcrc = 5'h1F;
    bit          mseen = 1'b0;
    int          mxfer = 0;
    int          mword_xfer = 0;

    task automatic check_regs();
        chk("R9 out_valid", 32'(out_valid), 32'(mv));
        chk("R8 proto_err", 32'(proto_err), 32'(merr));
        if (mv) begin
            if (mkind == 3) begin
                chk("R5 preamble", 32'(out_word[19:18]), 32'(mword[19:18]));
                chk("R5 tag", 32'(out_word[17:14]), 32'(mword[17:14]));
                if (mword_xfer > 1)
                    chk("R7 crc after restart", 32'(out_word[13:9]), 32'(mword[13:9]));
                else
                    chk("R6 crc", 32'(out_word[13:9]), 32'(mword[13:9]));
                chk("R5 low zeros", 32'(out_word[8:0]), 32'(mword[8:0]));
            end else begin
                chk("R1 preamble", 32'(out_word[19:18]), 32'(mword[19:18]));
                if (mkind == 0)
                    chk("R4 command payload", 32'(out_word[17:2]), 32'(mword[17:2]));
                else
                    chk("R1 data payload", 32'(out_word[17:2]), 32'(mword[17:2]));
                chk("R2 odd parity", 32'(out_word[1]), 32'(mword[1]));
                chk("R3 even parity", 32'(out_word[0]), 32'(mword[0]));
            end
        end
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin : main
        logic [7:0] lfsr;
        int idx;
        int stall_left;
        bit rdy;
        bit take;
        logic [4:0] c;
        bit s;
        lfsr = 8'hA5;
        // transfer 1: read command, four data words, CRC, with stalls
        push(0, 16'h8034, 1, 0);
        push(1, 16'h1234, 0, 0);
        push(2, 16'hFFFF, 0, 3);
        push(2, 16'h0000, 0, 0);
        push(2, 16'hA5C3, 0, 0);
        push(3, 16'hDEAD, 0, 2);
        // transfer 2: write command, one data word, CRC
        push(0, 16'h0051, 1, 0);
        push(1, 16'h5555, 0, 0);
        push(3, 16'h0000, 0, 0);
        // transfer 3: start pulse with the first data word itself
        push(1, 16'hAAAA, 1, 0);
        push(2, 16'h0F0F, 0, 0);
        push(3, 16'h0000, 0, 0);
        // transfer 4: CRC requested with no data (R8)
        push(0, 16'h00FE, 1, 0);
        push(3, 16'h0000, 0, 0);
        // transfer 5: normal again, error flag must stay set
        push(0, 16'h7001, 1, 0);
        push(1, 16'h0001, 0, 0);
        push(3, 16'h0000, 0, 0);

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R10 reset state
        chk("R10 out_valid after reset", 32'(out_valid), 32'd0);
        chk("R10 proto_err after reset", 32'(proto_err), 32'd0);
        chk("R10 in_ready after reset", 32'(in_ready), 32'd1);

        idx = 0;
        stall_left = 0;
        while (idx < q_kind.size() || mv) begin
            if (idx > 0) @(negedge clk);
            check_regs();
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            if (stall_left > 0) begin
                rdy = 1'b0;
                stall_left--;
            end else begin
                rdy = lfsr[0] | lfsr[3] | (idx >= q_kind.size());
            end
            out_ready = rdy;
            if (idx < q_kind.size()) begin
                in_valid   = 1'b1;
                in_kind    = 2'(q_kind[idx]);
                in_payload = q_pay[idx];
                sot        = q_sot[idx];
            end else begin
                in_valid = 1'b0;
                sot      = 1'b0;
            end
            #1;
            chk("R9 in_ready", 32'(in_ready), 32'(!mv || rdy));
            take = in_valid && (!mv || rdy);
            s = sot ? 1'b0 : mseen;
            c = sot ? 5'h1F : mcrc;
            if (sot && take) mxfer++;
            if (take) begin
                mword = ref_word(q_kind[idx], in_payload, c);
                mkind = q_kind[idx];
                mword_xfer = mxfer;
                mv = 1'b1;
                if (mkind == 1 || mkind == 2) begin
                    mcrc  = ref_crc(c, in_payload);
                    mseen = 1'b1;
                end else begin
                    mcrc  = c;
                    mseen = s;
                end
                if (mkind == 3 && !s) merr = 1'b1;
                stall_left = q_stall[idx];
                idx++;
            end else begin
                if (rdy) mv = 1'b0;
                mcrc  = c;
                mseen = s;
            end
            @(posedge clk);
        end
        @(negedge clk);
        check_regs();
        chk("R8 flag left set at end", 32'(proto_err), 32'd1);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule